// File: doc/BRIEF.md
# PLL Divider Configuration Loader

This block keeps the configuration that a frequency synthesizer's divider logic reads: a 9-bit feedback divider value, a 2-bit output divider select and a spread-spectrum enable bit. The configuration can be written through two paths. The first is a parallel word with an active-low strobe. The second is a three-wire serial port with a serial clock, serial data and a load line. All inputs are taken as already synchronized to the fast system clock `clk_i`. Every edge on the strobe, the serial clock and the load line is found inside the block by comparing each input with its value one cycle earlier.

While the parallel strobe is low, the parallel word flows through to the feedback value and the output divider is held at divide-by-2. Raising the strobe freezes the value. Serial data is shifted in with the most significant bit first. The frame is fourteen slots long: two don't-care slots, then the spread-spectrum bit, then the two select bits, then the nine feedback bits. A rising edge on the load line copies the shifted word into the configuration. While the load line stays high, every further serial clock edge updates the configuration at once. Any serial transfer ends parallel flow-through until the strobe falls again. A flag reports when the feedback value lies outside the range in which the PLL can lock.

All outputs are registered. A change at the inputs reaches the outputs at the first clock edge that samples it.

Top module: `pll_cfg_loader`

## Requirements
- R1: After reset the outputs are m_o = M_RST (200), n_sel_o = 2'b01 (divide-by-2) and ssc_en_o = 0.
- R2: After a falling edge of par_load_ni, and for as long as it stays low, m_o takes par_m_i one clock later and n_sel_o is 2'b01.
- R3: While par_load_ni is high and no serial transfer occurs, m_o, n_sel_o and ssc_en_o keep their values, whatever par_m_i does.
- R4: With par_load_ni high, every rising edge of ser_clk_i shifts ser_dat_i into the frame. Slots are taken most significant first in this order: two don't-care slots, the spread-spectrum bit, select bit 1, select bit 0, then feedback bits 8 down to 0.
- R5: A rising edge of ser_load_i loads the shifted frame: m_o = last nine bits, n_sel_o = the two bits before them (00 = /1, 01 = /2, 10 = /4, 11 = /8), ssc_en_o = the bit before those.
- R6: After ser_load_i falls, further shifting leaves the outputs unchanged until the next transfer.
- R7: While ser_load_i is high, each serial clock rising edge that shifts also updates the outputs with the new frame contents.
- R8: A serial transfer ends parallel flow-through. m_o ignores par_m_i until the next falling edge of par_load_ni.
- R9: If a serial transfer and parallel flow-through fall in the same cycle, the serial value wins.
- R10: m_range_err_o is 1 exactly when m_o < M_MIN (125) or m_o > M_MAX (350).
- R11: While par_load_ni is low, serial clock edges do not shift the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset to power-up defaults |
| par_m_i | input | 9 | Parallel feedback divider word |
| par_load_ni | input | 1 | Parallel strobe: flow-through while low, latch on rise |
| ser_clk_i | input | 1 | Serial shift clock (sampled) |
| ser_dat_i | input | 1 | Serial data |
| ser_load_i | input | 1 | Serial load line |
| m_o | output | 9 | Active feedback divider value |
| n_sel_o | output | 2 | Active output divider select |
| ssc_en_o | output | 1 | Spread-spectrum enable |
| m_range_err_o | output | 1 | Feedback value outside the lock range |

## Verification
The bench builds the block with its default parameters: a reset value of 200 and lock limits of 125 and 350. With these values both limits, and the codes just outside them, can be reached from the parallel word and from a serial frame, so the range flag is tested at its edges. A cycle model in the bench follows the sampled edges of the strobe, the serial clock and the load line. This exercises the transparent and latched behaviour of both paths, and it catches a serial load that coincides with parallel flow-through.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;
  localparam int unsigned M_W       = 9;
  localparam int unsigned N_W       = 2;
  localparam int unsigned NULL_W    = 2;
  localparam int unsigned PAYLOAD_W = 1 + N_W + M_W;
  localparam int unsigned FRAME_W   = NULL_W + PAYLOAD_W;

  typedef struct packed {
    logic           ssc;
    logic [N_W-1:0] n;
    logic [M_W-1:0] m;
  } div_cfg_t;

  localparam logic [N_W-1:0] N_DIV2 = 2'b01;
endpackage

// File: rtl/pll_cfg_sampler.sv
module pll_cfg_sampler #(
  parameter int unsigned W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] prev_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_o[i] <= RST_VAL[i];
      else         prev_o[i] <= sig_i[i];
    end
  end
endmodule

// File: rtl/pll_cfg_shift.sv
module pll_cfg_shift #(
  parameter int unsigned PAYLOAD_W = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 shift_en_i,
  input  logic                 dat_i,
  output logic [PAYLOAD_W-1:0] frame_q_o,
  output logic [PAYLOAD_W-1:0] frame_nxt_o
);
  // Leading don't-care slots drop off the top; only payload is stored.
  always_comb begin
    frame_nxt_o = frame_q_o;
    if (shift_en_i) frame_nxt_o = {frame_q_o[PAYLOAD_W-2:0], dat_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) frame_q_o <= '0;
    else         frame_q_o <= frame_nxt_o;
  end

  // R4: newest bit lands in the LSB
  a_r4_shift_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en_i |=> frame_q_o[0] == $past(dat_i));
endmodule

// File: rtl/pll_cfg_regs.sv
module pll_cfg_regs
  import pll_cfg_pkg::*;
#(
  parameter int unsigned M_RST = 200
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ser_evt_i,
  input  div_cfg_t       ser_cfg_i,
  input  logic           par_fall_i,
  input  logic           par_low_i,
  input  logic [M_W-1:0] par_m_i,
  output div_cfg_t       cfg_o
);
  logic follow_q, follow_nxt;

  assign follow_nxt = par_fall_i | (follow_q & par_low_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o    <= '{ssc: 1'b0, n: N_DIV2, m: M_W'(M_RST)};
      follow_q <= 1'b0;
    end else if (ser_evt_i) begin
      cfg_o    <= ser_cfg_i;
      follow_q <= 1'b0;
    end else begin
      follow_q <= follow_nxt;
      if (follow_nxt) begin
        cfg_o.m <= par_m_i;
        cfg_o.n <= N_DIV2;
      end
    end
  end

  // R2: parallel mode pins the output divider at /2
  a_r2_par_n_div2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    follow_q |-> cfg_o.n == N_DIV2);
  // R2: flow-through tracks the parallel word
  a_r2_par_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (follow_q && par_low_i && !ser_evt_i) |=> cfg_o.m == $past(par_m_i));
  // R3: strobe high and no serial event holds the configuration
  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!par_low_i && !ser_evt_i) |=> $stable(cfg_o));
endmodule

// File: rtl/pll_cfg_loader.sv
module pll_cfg_loader
  import pll_cfg_pkg::*;
#(
  parameter int unsigned M_RST = 200,
  parameter int unsigned M_MIN = 125,
  parameter int unsigned M_MAX = 350
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [M_W-1:0] par_m_i,
  input  logic           par_load_ni,
  input  logic           ser_clk_i,
  input  logic           ser_dat_i,
  input  logic           ser_load_i,
  output logic [M_W-1:0] m_o,
  output logic [N_W-1:0] n_sel_o,
  output logic           ssc_en_o,
  output logic           m_range_err_o
);
  localparam logic [M_W-1:0] M_LO = M_W'(M_MIN);
  localparam logic [M_W-1:0] M_HI = M_W'(M_MAX);
  localparam int unsigned    SIG_W = 3;
  localparam int unsigned    I_PAR = 2, I_LD = 1, I_CK = 0;

  logic [SIG_W-1:0]     sig_now, sig_prev;
  logic                 par_fall, ld_rise, ck_rise, shift_en, ser_evt;
  logic [PAYLOAD_W-1:0] frame_q, frame_nxt;
  div_cfg_t             cfg;

  assign sig_now = {par_load_ni, ser_load_i, ser_clk_i};

  pll_cfg_sampler #(.W(SIG_W), .RST_VAL(3'b100)) u_sampler (
    .clk_i (clk_i), .rst_ni(rst_ni), .sig_i(sig_now), .prev_o(sig_prev)
  );

  assign par_fall = ~sig_now[I_PAR] &  sig_prev[I_PAR];
  assign ld_rise  =  sig_now[I_LD]  & ~sig_prev[I_LD];
  assign ck_rise  =  sig_now[I_CK]  & ~sig_prev[I_CK];
  assign shift_en = ck_rise & par_load_ni;
  assign ser_evt  = ld_rise | (ser_load_i & shift_en);

  pll_cfg_shift #(.PAYLOAD_W(PAYLOAD_W)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .shift_en_i(shift_en), .dat_i(ser_dat_i),
    .frame_q_o(frame_q), .frame_nxt_o(frame_nxt)
  );

  pll_cfg_regs #(.M_RST(M_RST)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .ser_evt_i(ser_evt),
    .ser_cfg_i(div_cfg_t'(frame_nxt)), .par_fall_i(par_fall),
    .par_low_i(~par_load_ni), .par_m_i(par_m_i), .cfg_o(cfg)
  );

  assign m_o           = cfg.m;
  assign n_sel_o       = cfg.n;
  assign ssc_en_o      = cfg.ssc;
  assign m_range_err_o = (cfg.m < M_LO) || (cfg.m > M_HI);

  // R5: load rise without a shift copies the stored frame
  a_r5_xfer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_rise && !shift_en) |=> cfg == div_cfg_t'($past(frame_q)));
  // R11: strobe low freezes the shift register
  a_r11_no_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !par_load_ni |=> $stable(frame_q));
endmodule

// File: tb/pll_cfg_loader_tb.sv
module pll_cfg_loader_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [8:0] pm = '0;
  logic pld = 1'b1, sclk = 1'b0, sdat = 1'b0, sload = 1'b0;
  logic [8:0] m_o;
  logic [1:0] n_o;
  logic ssc_o, err_o;

  pll_cfg_loader dut_i (
    .clk_i(clk), .rst_ni(rst_n), .par_m_i(pm), .par_load_ni(pld),
    .ser_clk_i(sclk), .ser_dat_i(sdat), .ser_load_i(sload),
    .m_o(m_o), .n_sel_o(n_o), .ssc_en_o(ssc_o), .m_range_err_o(err_o)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_req = "R1";

  // behavioural reference
  int mm, mn, ms;
  bit follow, pld_p, sload_p, sclk_p;
  bit sq[$];
  bit rc, lr, pf, sh, ev;
  int fv;

  function automatic int frame_val();
    int v = 0;
    foreach (sq[i]) v = v * 2 + int'(sq[i]);
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mm = 200; mn = 1; ms = 0; follow = 0;
      pld_p = 1; sload_p = 0; sclk_p = 0;
      sq.delete();
      for (int i = 0; i < 14; i++) sq.push_back(1'b0);
    end else begin
      rc = sclk && !sclk_p;
      lr = sload && !sload_p;
      pf = !pld && pld_p;
      sh = rc && pld;
      if (sh) begin
        sq.push_back(sdat);
        void'(sq.pop_front());
      end
      ev = lr || (sload && sh);
      if (ev) begin
        fv = frame_val();
        mm = fv & 511; mn = (fv >> 9) & 3; ms = (fv >> 11) & 1;
        follow = 0;
      end else begin
        follow = pf || (follow && !pld);
        if (follow) begin mm = int'(pm); mn = 1; end
      end
      pld_p = pld; sload_p = sload; sclk_p = sclk;
    end
  end

  task automatic check(string req, string fld, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d", req, fld, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(cur_req, "m", int'(m_o), mm);
      check(cur_req, "n", int'(n_o), mn);
      check(cur_req, "ssc", int'(ssc_o), ms);
      check("R10", "err", int'(err_o), (mm < 125 || mm > 350) ? 1 : 0);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ser_bit(bit b);
    sdat = b; sclk = 0; cyc(2);
    sclk = 1; cyc(2);
    sclk = 0;
  endtask

  task automatic send_frame(int s, int n, int m);
    int f = (s << 11) | (n << 9) | m;
    for (int i = 13; i >= 0; i--) ser_bit(bit'((f >> i) & 1));
    cyc(1);
  endtask

  task automatic pulse_load();
    sload = 1; cyc(2); sload = 0; cyc(2);
  endtask

  task automatic expect_cfg(string req, int m, int n, int s);
    check(req, "m", int'(m_o), m);
    check(req, "n", int'(n_o), n);
    check(req, "ssc", int'(ssc_o), s);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1; errors++;
      $display("FAIL %s watchdog act=running exp=finished", cur_req);
      summary();
      $finish;
    end
  end

  initial begin
    cyc(3); rst_n = 1; cyc(2);
    cur_req = "R1";  expect_cfg("R1", 200, 1, 0);
    check("R1", "err", int'(err_o), 0);

    cur_req = "R2"; pld = 0; pm = 150; cyc(2); expect_cfg("R2", 150, 1, 0);
    pm = 300; cyc(2); check("R2", "m", int'(m_o), 300);

    cur_req = "R10";
    pm = 124; cyc(2); check("R10", "err", int'(err_o), 1);
    pm = 125; cyc(2); check("R10", "err", int'(err_o), 0);
    pm = 350; cyc(2); check("R10", "err", int'(err_o), 0);
    pm = 351; cyc(2); check("R10", "err", int'(err_o), 1);

    cur_req = "R3"; pm = 260; cyc(2); pld = 1; cyc(1); pm = 7; cyc(3);
    check("R3", "m", int'(m_o), 260);

    cur_req = "R4"; send_frame(1, 3, 341);
    check("R4", "m", int'(m_o), 260);
    cur_req = "R5"; pulse_load(); expect_cfg("R5", 341, 3, 1);

    cur_req = "R6"; send_frame(0, 0, 400); cyc(2);
    expect_cfg("R6", 341, 3, 1);
    cur_req = "R5"; pulse_load(); expect_cfg("R5", 400, 0, 0);
    check("R10", "err", int'(err_o), 1);

    cur_req = "R7"; sload = 1; cyc(2); expect_cfg("R7", 400, 0, 0);
    ser_bit(1'b0); cyc(1); expect_cfg("R7", 288, 1, 0);
    send_frame(1, 2, 222); expect_cfg("R7", 222, 2, 1);
    cur_req = "R6"; sload = 0; cyc(2); send_frame(0, 1, 130);
    expect_cfg("R6", 222, 2, 1);

    cur_req = "R8"; pm = 180; pld = 0; cyc(2); expect_cfg("R8", 180, 1, 1);
    pulse_load(); expect_cfg("R8", 130, 1, 0);
    pm = 190; cyc(3); check("R8", "m", int'(m_o), 130);
    pld = 1; cyc(2); pld = 0; cyc(2); check("R8", "m", int'(m_o), 190);

    cur_req = "R11"; send_frame(1, 3, 20);
    pld = 1; cyc(2); pulse_load(); expect_cfg("R11", 130, 1, 0);

    cur_req = "R9"; pld = 0; pm = 210; cyc(2); check("R9", "m", int'(m_o), 210);
    sload = 1; pm = 220; cyc(2); expect_cfg("R9", 130, 1, 0);
    sload = 0; cyc(2); check("R9", "m", int'(m_o), 130);

    done = 1;
    summary();
    $finish;
  end
endmodule